// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block drives calibration for the digital back end of an oversampling converter. A host writes a 3-bit calibration code, together with a range flag, into a small write port. The block then steps through the phases of the calibration. In each phase it selects the input source to measure: an internal shorted node, the internal reference node, or the external system input. It also requests one settled conversion through a request/valid handshake. The zero-scale and full-scale readings become an offset coefficient, which is the zero reading, and a fixed-point gain coefficient, which is the nominal span divided by the measured span.

Every accepted command produces a one-cycle pulse on the filter reset output. The active-low ready output rises while the calibration runs. It falls again only after two things have happened: both coefficients hold their new values, and one more conversion on the external input has been taken, so the filter has resettled. The system calibration has two steps, each started by the host. Running the zero-scale step again on its own moves the offset but keeps the gain slope.

A synchronisation input resets the filter and returns the sequencer to idle without losing stored coefficients. A 30-bit restoring divider produces one quotient bit per cycle.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset the outputs are as follows: `ready_n_o`=1, `conv_req_o`=0, `filt_rst_o`=0, `src_sel_o`=0, `offset_o`=0 and `gain_o`=2^GF (unity gain, GF fractional bits).
- R2: A write of code 001, 010 or 011 while idle is accepted. The cycle after the write, `filt_rst_o` is high for exactly one cycle and `ready_n_o` keeps its previous value. The following cycle `ready_n_o` is 1, and it stays 1 until the calibration completes.
- R3: Code 001 (self-calibration) requests two conversions, first with `src_sel_o`=1 (shorted node) and then with `src_sel_o`=2 (reference node). The offset becomes the first reading, and the gain is computed by R6 from both readings.
- R4: Code 010 (system zero step) requests one conversion with `src_sel_o`=0 (external input). The offset becomes that reading and the gain does not change, including when the step is repeated after a complete system calibration.
- R5: Code 011 (system full step) requests one conversion with `src_sel_o`=0. The gain is computed by R6 from that reading and the most recent zero reading of either mode. The offset does not change.
- R6: Gain = floor(ideal * 2^GF / (full - zero)), with GF=14 and GW=16 by default, saturated to 2^GW-1 when it exceeds that value or when full <= zero. The ideal span is 2^DW-1 in unipolar range and 2^(DW-1)-1 in bipolar range. The range is sampled with the command: `bip_i`=1 means bipolar.
- R7: After the coefficients are updated, the block requests one more conversion with `src_sel_o`=0. `ready_n_o` falls on the clock edge that accepts that conversion, and at that point both coefficients already show their new values.
- R8: A write while a calibration runs has no effect and produces no filter reset pulse. A write of any code other than 001, 010 or 011 also has no effect and produces no filter reset pulse.
- R9: While `sync_i` is high, `filt_rst_o` is high. One cycle later the block is idle, with `conv_req_o`=0 and `ready_n_o`=1, and the stored coefficients are retained.
- R10: `conv_req_o` stays high until `conv_valid_i` is sampled high, and `conv_data_i` is taken on that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronisation: reset filter, return to idle |
| wr_en_i | input | 1 | Host write strobe for the calibration code |
| wr_mode_i | input | 3 | Calibration code |
| bip_i | input | 1 | Range flag sampled with the code: 1 bipolar, 0 unipolar |
| conv_req_o | output | 1 | Request for one settled conversion |
| conv_valid_i | input | 1 | Conversion result present |
| conv_data_i | input | DW | Conversion result code |
| src_sel_o | output | 2 | Measured source: 0 external, 1 shorted node, 2 reference |
| filt_rst_o | output | 1 | Digital filter reset |
| ready_n_o | output | 1 | Ready, active low |
| offset_o | output | DW | Offset coefficient |
| gain_o | output | GW | Gain coefficient, GF fractional bits |

## Verification
The hardest situations to reach from the ports are those where a command arrives while the sequencer is in a busy phase. The first is a host write during a pending conversion. The second is a synchronisation pulse in the middle of a step. To reach them, the bench waits on `conv_req_o` with a known source selected and injects the write or the pulse before answering the request. It then shows that the source order, the coefficients and the filter reset output are as if the intrusion had not happened, or that the block is idle with its coefficients intact.

Gain saturation is reached by chaining system steps so that the stored zero reading lies above, or just below, the next full-scale reading. Repeating the zero step after a saturated slope shows that the gain is kept.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
   localparam logic [2:0] CODE_SELF     = 3'b001;
   localparam logic [2:0] CODE_SYS_ZERO = 3'b010;
   localparam logic [2:0] CODE_SYS_FULL = 3'b011;

   typedef enum logic [1:0] {
      SRC_EXT   = 2'd0,
      SRC_SHORT = 2'd1,
      SRC_REF   = 2'd2
   } cal_src_e;

   typedef enum logic [1:0] {
      K_SELF = 2'd0,
      K_ZERO = 2'd1,
      K_FULL = 2'd2
   } cal_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_MEAS_A,
      ST_MEAS_B,
      ST_DIV_GO,
      ST_DIVIDE,
      ST_SETTLE
   } cal_state_e;
endpackage

// File: rtl/adc_cal_cmd_decode.sv
module adc_cal_cmd_decode
   import adc_cal_pkg::*;
(
   input  logic       wr_en_i,
   input  logic [2:0] code_i,
   input  logic       idle_i,
   output logic       accept_o,
   output cal_kind_e  kind_o
);
   logic known;

   always_comb begin
      known  = 1'b1;
      kind_o = K_SELF;
      case (code_i)
         CODE_SELF:     kind_o = K_SELF;
         CODE_SYS_ZERO: kind_o = K_ZERO;
         CODE_SYS_FULL: kind_o = K_FULL;
         default:       known  = 1'b0;
      endcase
      accept_o = wr_en_i && idle_i && known;
   end
endmodule

// File: rtl/adc_cal_divider.sv
module adc_cal_divider #(
   parameter int NUM_W = 30,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);
   localparam int CW = $clog2(NUM_W + 1);

   logic [CW-1:0]    cnt_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] quo_q;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;

   initial begin
      assert (NUM_W >= 2 && DEN_W >= 2)
         else $error("divider widths too small");
   end

   always_comb begin
      trial = {rem_q, quo_q[NUM_W-1]};
      diff  = trial - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         quo_q  <= '0;
         done_o <= 1'b0;
      end else if (abort_i) begin
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CW'(NUM_W);
         rem_q  <= '0;
         den_q  <= den_i;
         quo_q  <= num_i;
         done_o <= 1'b0;
      end else if (cnt_q != '0) begin
         if (!diff[DEN_W]) begin
            rem_q <= diff[DEN_W-1:0];
            quo_q <= {quo_q[NUM_W-2:0], 1'b1};
         end else begin
            rem_q <= trial[DEN_W-1:0];
            quo_q <= {quo_q[NUM_W-2:0], 1'b0};
         end
         cnt_q  <= cnt_q - 1'b1;
         done_o <= (cnt_q == CW'(1));
      end else begin
         done_o <= 1'b0;
      end
   end

   assign quo_o = quo_q;

   AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !abort_i) |-> (cnt_q == '0)); // R6
   AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && den_q != '0) |-> (rem_q < den_q)); // R6
endmodule

// File: rtl/adc_cal_coef_store.sv
module adc_cal_coef_store #(
   parameter int DW = 16,
   parameter int GW = 16,
   parameter int GF = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_zero_i,
   input  logic [DW-1:0] zero_in_i,
   input  logic          ld_off_i,
   input  logic [DW-1:0] off_in_i,
   input  logic          ld_gain_i,
   input  logic [GW-1:0] gain_in_i,
   output logic [DW-1:0] zero_o,
   output logic [DW-1:0] off_o,
   output logic [GW-1:0] gain_o
);
   localparam logic [GW-1:0] UNITY = GW'(1) << GF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_o <= '0;
         off_o  <= '0;
         gain_o <= UNITY;
      end else begin
         if (ld_zero_i) zero_o <= zero_in_i;
         if (ld_off_i)  off_o  <= off_in_i;
         if (ld_gain_i) gain_o <= gain_in_i;
      end
   end
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
   import adc_cal_pkg::*;
#(
   parameter int DW = 16,
   parameter int GF = 14,
   parameter int GW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_i,
   input  logic          wr_en_i,
   input  logic [2:0]    wr_mode_i,
   input  logic          bip_i,
   output logic          conv_req_o,
   input  logic          conv_valid_i,
   input  logic [DW-1:0] conv_data_i,
   output logic [1:0]    src_sel_o,
   output logic          filt_rst_o,
   output logic          ready_n_o,
   output logic [DW-1:0] offset_o,
   output logic [GW-1:0] gain_o
);
   localparam int NW = DW + GF;

   initial begin
      assert (DW >= 4) else $error("DW must be at least 4");
      assert (GF >= 1 && GF < GW) else $error("GF must lie in 1..GW-1");
   end

   cal_state_e    state;
   cal_kind_e     kind_q;
   cal_kind_e     kind_dec;
   logic          bip_q;
   logic          ready_n_q;
   logic          accept;
   logic [DW-1:0] full_q;
   logic [DW-1:0] zero_q;
   logic          span_bad;
   logic [DW-1:0] den;
   logic [NW-1:0] num;
   logic [NW-1:0] quo;
   logic          div_start;
   logic          div_done;
   logic [GW-1:0] gain_val;
   logic          take;
   logic          ld_zero;
   logic          ld_off;
   logic          ld_gain;
   logic [DW-1:0] off_in;

   adc_cal_cmd_decode u_dec (
      .wr_en_i  (wr_en_i),
      .code_i   (wr_mode_i),
      .idle_i   (state == ST_IDLE),
      .accept_o (accept),
      .kind_o   (kind_dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind_q    <= K_SELF;
         bip_q     <= 1'b0;
         ready_n_q <= 1'b1;
         full_q    <= '0;
      end else if (sync_i) begin
         state     <= ST_IDLE;
         ready_n_q <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               state  <= ST_START;
               kind_q <= kind_dec;
               bip_q  <= bip_i;
            end
            ST_START: begin
               state     <= ST_MEAS_A;
               ready_n_q <= 1'b1;
            end
            ST_MEAS_A: if (conv_valid_i) begin
               case (kind_q)
                  K_SELF:  state <= ST_MEAS_B;
                  K_ZERO:  state <= ST_SETTLE;
                  default: begin
                     full_q <= conv_data_i;
                     state  <= ST_DIV_GO;
                  end
               endcase
            end
            ST_MEAS_B: if (conv_valid_i) begin
               full_q <= conv_data_i;
               state  <= ST_DIV_GO;
            end
            ST_DIV_GO: state <= ST_DIVIDE;
            ST_DIVIDE: if (div_done) state <= ST_SETTLE;
            ST_SETTLE: if (conv_valid_i) begin
               ready_n_q <= 1'b0;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // source selection and handshake
   always_comb begin
      conv_req_o = (state == ST_MEAS_A) || (state == ST_MEAS_B) || (state == ST_SETTLE);
      if (state == ST_MEAS_A && kind_q == K_SELF)
         src_sel_o = SRC_SHORT;
      else if (state == ST_MEAS_B)
         src_sel_o = SRC_REF;
      else
         src_sel_o = SRC_EXT;
   end

   assign filt_rst_o = sync_i || (state == ST_START);
   assign ready_n_o  = ready_n_q;

   // span and nominal numerator
   always_comb begin
      span_bad = !(full_q > zero_q);
      den      = full_q - zero_q;
      if (bip_q)
         num = {1'b0, {(DW-1){1'b1}}, {GF{1'b0}}};
      else
         num = {{DW{1'b1}}, {GF{1'b0}}};
   end

   assign div_start = (state == ST_DIV_GO) && !sync_i;

   adc_cal_divider #(.NUM_W(NW), .DEN_W(DW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .abort_i (sync_i),
      .num_i   (num),
      .den_i   (den),
      .done_o  (div_done),
      .quo_o   (quo)
   );

   generate
      if (NW > GW) begin : g_trim
         assign gain_val = (span_bad || (|quo[NW-1:GW])) ? '1 : quo[GW-1:0];
      end else begin : g_wide
         assign gain_val = span_bad ? '1 : GW'(quo);
      end
   endgenerate

   always_comb begin
      take    = conv_valid_i && !sync_i;
      ld_zero = (state == ST_MEAS_A) && take && (kind_q != K_FULL);
      ld_off  = ((state == ST_MEAS_A) && take && (kind_q == K_ZERO)) ||
                ((state == ST_DIVIDE) && div_done && !sync_i && (kind_q == K_SELF));
      ld_gain = (state == ST_DIVIDE) && div_done && !sync_i;
      off_in  = (state == ST_MEAS_A) ? conv_data_i : zero_q;
   end

   adc_cal_coef_store #(.DW(DW), .GW(GW), .GF(GF)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_zero_i (ld_zero),
      .zero_in_i (conv_data_i),
      .ld_off_i  (ld_off),
      .off_in_i  (off_in),
      .ld_gain_i (ld_gain),
      .gain_in_i (gain_val),
      .zero_o    (zero_q),
      .off_o     (offset_o),
      .gain_o    (gain_o)
   );

   AST_CMD_FILT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !sync_i) |=> (filt_rst_o && $stable(ready_n_o))); // R2
   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && state != ST_IDLE) |=> (state != ST_START)); // R8
   AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (wr_mode_i == 3'b000 || wr_mode_i[2])) |=> (state != ST_START)); // R8
   AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_n_o) |-> $past(conv_valid_i && conv_req_o && src_sel_o == SRC_EXT)); // R7
   AST_ZERO_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && kind_q == K_ZERO) |=> $stable(gain_o)); // R4
   AST_FULL_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && kind_q == K_FULL) |=> $stable(offset_o)); // R5
   AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (!conv_req_o && ready_n_o)); // R9
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req_o && !conv_valid_i && !sync_i) |=> conv_req_o); // R10
endmodule

// File: tb/tb_adc_cal_sequencer.sv
`timescale 1ns/1ps
module tb_adc_cal_sequencer;
   localparam int DW = 16;
   localparam int GF = 14;
   localparam int GW = 16;
   localparam int NV = 10;

   // {code, bipolar, first reading, second reading}
   localparam logic [35:0] VEC [NV] = '{
      {3'b001, 1'b0, 16'd100,   16'd60000},
      {3'b010, 1'b0, 16'd200,   16'd0},
      {3'b011, 1'b0, 16'd65000, 16'd0},
      {3'b010, 1'b1, 16'd32800, 16'd0},
      {3'b011, 1'b1, 16'd65000, 16'd0},
      {3'b001, 1'b1, 16'd32768, 16'd65535},
      {3'b010, 1'b0, 16'd32800, 16'd0},
      {3'b011, 1'b0, 16'd32810, 16'd0},
      {3'b011, 1'b0, 16'd100,   16'd0},
      {3'b010, 1'b0, 16'd500,   16'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_i = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_mode = 3'b000;
   logic          bip = 1'b0;
   logic          conv_req;
   logic          conv_valid = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic [1:0]    src_sel;
   logic          filt_rst;
   logic          ready_n;
   logic [DW-1:0] offset;
   logic [GW-1:0] gain;

   int errors = 0;
   int checks = 0;
   int exp_off = 0;
   int exp_gain = 16384;
   int last_zero = 0;

   always #2 clk = ~clk;

   adc_cal_sequencer #(.DW(DW), .GF(GF), .GW(GW)) dut (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .wr_en_i(wr_en),
      .wr_mode_i(wr_mode), .bip_i(bip), .conv_req_o(conv_req),
      .conv_valid_i(conv_valid), .conv_data_i(conv_data), .src_sel_o(src_sel),
      .filt_rst_o(filt_rst), .ready_n_o(ready_n), .offset_o(offset), .gain_o(gain)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int calc_gain(input logic bp, input int full, input int zero);
      longint ideal;
      longint q;
      if (full <= zero) return 65535;
      ideal = bp ? 64'd32767 : 64'd65535;
      q = (ideal * 64'd16384) / longint'(full - zero);
      if (q > 64'd65535) return 65535;
      return int'(q);
   endfunction

   task automatic do_write(input logic [2:0] code, input logic bp, input logic acc, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_mode = code; bip = bp;
      @(negedge clk);
      wr_en = 1'b0;
      chk({tag, " filter reset after write"}, int'(filt_rst), int'(acc));
      if (acc) begin
         @(negedge clk);
         chk("R2 ready high in progress", int'(ready_n), 1);
         chk("R2 filter reset lasts one cycle", int'(filt_rst), 0);
      end
   endtask

   task automatic serve(input logic [1:0] src, input int data, input int dly, input string tag);
      while (!conv_req) @(negedge clk);
      chk({tag, " source select"}, int'(src_sel), int'(src));
      chk("R2 ready high while busy", int'(ready_n), 1);
      for (int k = 0; k < dly; k++) begin
         @(negedge clk);
         chk("R10 request held", int'(conv_req), 1);
      end
      conv_valid = 1'b1; conv_data = DW'(data);
      @(negedge clk);
      conv_valid = 1'b0;
   endtask

   task automatic check_done(input string tag);
      chk("R7 ready low at completion", int'(ready_n), 0);
      chk({tag, " offset"}, int'(offset), exp_off);
      chk({tag, " gain"}, int'(gain), exp_gain);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ready_n", int'(ready_n), 1);
      chk("R1 reset conv_req", int'(conv_req), 0);
      chk("R1 reset filt_rst", int'(filt_rst), 0);
      chk("R1 reset src_sel", int'(src_sel), 0);
      chk("R1 reset offset", int'(offset), 0);
      chk("R1 reset gain", int'(gain), 16384);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] code;
         logic       bp;
         int         a;
         int         b;
         code = VEC[i][35:33];
         bp   = VEC[i][32];
         a    = int'(VEC[i][31:16]);
         b    = int'(VEC[i][15:0]);
         do_write(code, bp, 1'b1, "R2");
         case (code)
            3'b001: begin
               serve(2'd1, a, i % 3, "R3");
               serve(2'd2, b, 0, "R3");
               last_zero = a; exp_off = a;
               exp_gain = calc_gain(bp, b, a);
               serve(2'd0, 16'h1234, 1, "R7");
               check_done("R3 self");
            end
            3'b010: begin
               serve(2'd0, a, i % 3, "R4");
               last_zero = a; exp_off = a;
               serve(2'd0, 16'h0F0F, 0, "R7");
               check_done("R4 zero step");
            end
            default: begin
               serve(2'd0, a, i % 3, "R5");
               exp_gain = calc_gain(bp, a, last_zero);
               serve(2'd0, 16'h00AA, 2, "R7");
               check_done("R5 full step");
               chk("R6 gain formula", int'(gain), exp_gain);
            end
         endcase
      end

      // R8: unknown codes while idle
      do_write(3'b000, 1'b0, 1'b0, "R8 code 000");
      @(negedge clk);
      chk("R8 no request for code 000", int'(conv_req), 0);
      chk("R8 ready unchanged for code 000", int'(ready_n), 0);
      do_write(3'b101, 1'b0, 1'b0, "R8 code 101");
      @(negedge clk);
      chk("R8 no request for code 101", int'(conv_req), 0);
      chk("R8 ready unchanged for code 101", int'(ready_n), 0);

      // R8: write while busy during self-calibration
      do_write(3'b001, 1'b0, 1'b1, "R2");
      while (!conv_req) @(negedge clk);
      wr_en = 1'b1; wr_mode = 3'b011;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R8 busy write no filter reset", int'(filt_rst), 0);
      serve(2'd1, 1000, 0, "R8 busy still shorted");
      serve(2'd2, 50000, 0, "R3");
      last_zero = 1000; exp_off = 1000;
      exp_gain = calc_gain(1'b0, 50000, 1000);
      serve(2'd0, 16'h2222, 0, "R7");
      check_done("R8 busy write ignored");

      // R9: synchronisation in the middle of a zero step
      do_write(3'b010, 1'b0, 1'b1, "R2");
      while (!conv_req) @(negedge clk);
      sync_i = 1'b1;
      #1;
      chk("R9 filter reset during sync", int'(filt_rst), 1);
      @(negedge clk);
      sync_i = 1'b0;
      chk("R9 request dropped", int'(conv_req), 0);
      chk("R9 ready high", int'(ready_n), 1);
      chk("R9 offset retained", int'(offset), exp_off);
      chk("R9 gain retained", int'(gain), exp_gain);
      @(negedge clk);
      chk("R9 filter reset released", int'(filt_rst), 0);
      chk("R9 idle no request", int'(conv_req), 0);

      // R4 after sync: block accepts a fresh zero step
      do_write(3'b010, 1'b0, 1'b1, "R2");
      serve(2'd0, 777, 0, "R4");
      exp_off = 777; last_zero = 777;
      serve(2'd0, 16'h0001, 0, "R7");
      check_done("R4 zero after sync");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule